// File: doc/BRIEF.md
# Sticky Limit Status Alert Controller

This block collects out-of-limit flags from up to sixteen monitored quantities and turns them into one active-low alert line plus a set of latched status bits that software can inspect. Each source supplies a level input that is high while its measurement lies beyond its limit. The block latches every such event in a status bit, so that software polling at any rate still sees the event. A status bit is released only after the fault has gone away and software has read the register that holds it.

Software reaches the block through a byte-wide register bus with single-cycle read and write strobes. Two read-only status registers report the latched events. Two read/write mask registers let an interrupt handler silence a source that it is already servicing. The status bit of a masked source still follows its condition, so software can poll it and clear the mask once the fault is gone. The limit comparators and the serial management protocol sit outside this block.

Top module: `alert_status_ctrl`

## Requirements
- R1: When a source's condition input is high at a rising clock edge, its status bit is 1 after that edge.
- R2: A status bit that is 1 returns to 0 only at an edge where its status register is read while its condition is low. A read taken while the condition is high leaves the bit at 1. A bit that is set stays set with no read.
- R3: `alert_n` is registered and active low. After every edge it equals the inverse of the OR, over all sources, of (status bit AND NOT mask bit). This keeps it low after a fault ends, until the clearing read.
- R4: A mask bit of 1 keeps its source from pulling `alert_n` low, while that source's status bit still sets and reads back as in R1 and R2.
- R5: The mask registers are read/write at address 0x72 (bit k is source k) and 0x73 (bit k is source 8+k). Writing a mask bit back to 0 lets a source whose status bit is still set pull `alert_n` low at that write's edge.
- R6: The status registers are read at 0x70 (bit k is source k) and 0x71 (bit k is source 8+k). Writes to them change nothing.
- R7: `bus_rdata` is updated at the edge that samples `bus_rd` and holds its value otherwise. It returns the status value from before any clear at that edge. Reads of any other address return 0x00.
- R8: If a source's condition is high at the same edge as a read that would clear its bit, the bit is 1 after that edge.
- R9: Synchronous reset clears all status and mask bits and `bus_rdata`, and drives `alert_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 16 | Per-source out-of-limit level, bit n is source n |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| alert_n | output | 1 | Alert output, active low |

## Verification
On every cycle the assertions check several properties. A high condition always leaves its status bit set. A set bit never drops without a read of its register. The alert line always matches the status and mask state. Mask registers change only under a write to them, and read data changes only under a read strobe. The bench scenarios cover the rest: a read taken during a fault, a clear only on a later read, a condition rising in the same cycle as a clearing read, a masked source that still latches, re-enabling the alert by unmasking, ignored writes to status addresses, and the mapping of bit positions to addresses.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/alert_addr_dec.sv
module alert_addr_dec
  import alert_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_REGS = 2,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_BASE = 8'h72,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    for (int j = 0; j < NUM_REGS; j++) begin
      if (addr == ADDR_W'(STATUS_BASE + ADDR_W'(j))) begin
        kind = SEL_STATUS;
        idx  = IDX_W'(j);
      end
      if (addr == ADDR_W'(MASK_BASE + ADDR_W'(j))) begin
        kind = SEL_MASK;
        idx  = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_i,
  input  logic         clr_i,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d
);
  // set dominates; a clearing read only drops bits whose condition is low
  always_comb status_d = cond_i | (clr_i ? '0 : status_q);

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  // R1 and R8: a high condition always leaves its bit set
  assert_cond_sets_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(cond_i)) == $past(cond_i)));

  // R2: without a read, set bits stay set
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/mask_bank.sv
module mask_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_d
);
  always_comb mask_d = we_i ? wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  // R5: mask changes only under a write to this register
  assert_mask_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl
  import alert_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_BASE = 8'h72,
  localparam int NUM_SRC = NUM_REGS * REG_W,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] cond_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               alert_n
);
  sel_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic [REG_W-1:0]   status_arr [NUM_REGS];
  logic [REG_W-1:0]   mask_arr   [NUM_REGS];
  logic [NUM_SRC-1:0] status_all, status_nx, mask_all, mask_nx;
  logic [REG_W-1:0]   rdata_d;

  alert_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .STATUS_BASE(STATUS_BASE), .MASK_BASE(MASK_BASE)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .idx(idx)
  );

  for (genvar j = 0; j < NUM_REGS; j++) begin : g_reg
    logic clr_hit, wr_hit;
    assign clr_hit = bus_rd && (kind == SEL_STATUS) && (idx == IDX_W'(j));
    assign wr_hit  = bus_wr && (kind == SEL_MASK) && (idx == IDX_W'(j));

    status_bank #(.W(REG_W)) u_status (
      .clk(clk), .rst(rst),
      .cond_i(cond_i[j*REG_W +: REG_W]),
      .clr_i(clr_hit),
      .status_q(status_all[j*REG_W +: REG_W]),
      .status_d(status_nx[j*REG_W +: REG_W])
    );

    mask_bank #(.W(REG_W)) u_mask (
      .clk(clk), .rst(rst),
      .we_i(wr_hit), .wdata_i(bus_wdata),
      .mask_q(mask_all[j*REG_W +: REG_W]),
      .mask_d(mask_nx[j*REG_W +: REG_W])
    );

    assign status_arr[j] = status_all[j*REG_W +: REG_W];
    assign mask_arr[j]   = mask_all[j*REG_W +: REG_W];
  end

  always_comb begin
    case (kind)
      SEL_STATUS: rdata_d = status_arr[idx];
      SEL_MASK:   rdata_d = mask_arr[idx];
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      alert_n   <= 1'b1;
    end else begin
      if (bus_rd) bus_rdata <= rdata_d;
      alert_n <= ~|(status_nx & ~mask_nx);
    end
  end

  // R3: alert line tracks the latched, unmasked state
  assert_alert_match_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (alert_n == ~|(status_all & ~mask_all)));

  // R4: fully masked state keeps the alert released
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((status_all & ~mask_all) == '0) -> alert_n));

  // R7: read data moves only under a read strobe
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/alert_status_ctrl_tb.sv
`timescale 1ns/1ps
module alert_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cond_i;
  logic [7:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        alert_n;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  alert_status_ctrl u_dut (
    .clk(clk), .rst(rst), .cond_i(cond_i),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alert_n(alert_n)
  );

  // monitor: compares read data one edge after each read strobe
  always @(posedge clk) rd_seen <= bus_rd && !rst;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    bus_addr = a;
    bus_rd   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_alert(input logic e, input string t);
    n_tests++;
    if (alert_n !== e) begin
      n_fail++;
      $display("FAIL %s: alert_n actual=%0b expected=%0b", t, alert_n, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cond_i = '0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk_alert(1'b1, "R9 reset alert");
    rd(8'h70, 8'h00, "R9 reset status");
    rd(8'h73, 8'h00, "R9 reset mask");

    // R1 / R2 / R3: pulse fault, alert stays until clearing read
    cond_i[3] = 1'b1; tick(); cond_i[3] = 1'b0;
    chk_alert(1'b0, "R1 alert on fault");
    tick();
    chk_alert(1'b0, "R3 alert held after fault");
    rd(8'h70, 8'h08, "R1 status bit3");
    chk_alert(1'b1, "R3 alert released by read");
    rd(8'h70, 8'h00, "R2 cleared after read");

    // R2: read during fault keeps bit
    cond_i[9] = 1'b1; tick();
    rd(8'h71, 8'h02, "R6 status src9 in 0x71");
    rd(8'h71, 8'h02, "R2 read during fault keeps bit");
    chk_alert(1'b0, "R2 alert during fault");
    cond_i[9] = 1'b0; tick();
    chk_alert(1'b0, "R2 alert after fault before read");
    rd(8'h71, 8'h02, "R7 pre-clear value");
    rd(8'h71, 8'h00, "R2 cleared after subside and read");
    chk_alert(1'b1, "R2 alert released");

    // R4 / R5: masking
    wr(8'h73, 8'h02);
    rd(8'h73, 8'h02, "R5 mask readback 0x73");
    cond_i[9] = 1'b1; tick();
    chk_alert(1'b1, "R4 masked source silent");
    rd(8'h71, 8'h02, "R4 masked status still sets");
    cond_i[9] = 1'b0; tick();
    chk_alert(1'b1, "R4 masked silent after fault");
    wr(8'h73, 8'h00);
    chk_alert(1'b0, "R5 unmask re-enables alert");
    rd(8'h71, 8'h02, "R5 status still set");
    chk_alert(1'b1, "R5 alert released after clear");
    wr(8'h72, 8'h5A);
    rd(8'h72, 8'h5A, "R5 mask readback 0x72");
    rd(8'h73, 8'h00, "R5 0x73 untouched");
    wr(8'h72, 8'h00);

    // R6: writes to status ignored
    wr(8'h70, 8'hFF);
    wr(8'h71, 8'hFF);
    chk_alert(1'b1, "R6 status write no alert");
    rd(8'h70, 8'h00, "R6 write 0x70 ignored");
    rd(8'h71, 8'h00, "R6 write 0x71 ignored");

    // R8: set wins over clearing read
    cond_i[0] = 1'b1;
    rd(8'h70, 8'h00, "R8 pre-set value");
    cond_i[0] = 1'b0;
    rd(8'h70, 8'h01, "R8 set wins");
    rd(8'h70, 8'h00, "R8 later clear");

    // R6: bit position mapping across both registers
    cond_i = 16'h81A5; tick(); cond_i = '0;
    chk_alert(1'b0, "R3 multi-source alert");
    rd(8'h70, 8'hA5, "R6 low byte map");
    chk_alert(1'b0, "R3 alert held by high byte");
    rd(8'h71, 8'h81, "R6 high byte map");
    chk_alert(1'b1, "R3 all cleared");

    // R7: unmapped reads
    rd(8'h74, 8'h00, "R7 unmapped 0x74");
    rd(8'h6F, 8'h00, "R7 unmapped 0x6F");

    // R9: reset mid-run
    wr(8'h72, 8'hFF);
    cond_i[15] = 1'b1; tick(); cond_i[15] = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    chk_alert(1'b1, "R9 reset alert mid-run");
    rd(8'h72, 8'h00, "R9 mask cleared");
    rd(8'h71, 8'h00, "R9 status cleared");

    repeat (2) tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule